// File: doc/BRIEF.md
# Conditional Sum Adder

This block adds two unsigned N-bit operands and an incoming carry without letting the carry ripple through every position. For each bit it first builds two candidate results. One assumes the carry into that group is 0 and the other assumes it is 1. Each candidate holds a sum bit and a carry-out. Adjacent groups are then merged, one level at a time. In every merge, the carry-out candidates of the lower group drive multiplexers that choose which candidate of the upper group survives. Each merge doubles the group width. After ceil(log2 N) levels a single group spans the whole word.

The incoming carry is known from the start. The group that holds bit 0 therefore resolves it at once and carries a single settled result upward, with both of its candidate slots equal. A group that finds no partner at some level, which happens when N is not a power of two, moves up unchanged. The block is purely combinational and is meant to be placed between registers in a wider datapath.

Top module: `condSumAdder`

## Requirements
- R1: `sum` equals the low N bits of the arithmetic value `x + y + cin` for every input combination.
- R2: `cout` equals bit N of `x + y + cin`, that is, 1 exactly when the true total is 2^N or more.
- R3: For each bit position above 0, the single-bit candidates are as follows. The carry-in-0 sum is `x^y` and the carry-in-0 carry is `x&y`. The carry-in-1 sum is `~(x^y)` and the carry-in-1 carry is `x|y`.
- R4: The group holding bit 0 keeps one result at every level: its two candidate sum slices and its two candidate carries are identical.
- R5: A carry entering at bit 0 crosses every merge level correctly. With `x` all ones, `y` zero and `cin` 1, the result is `sum` zero and `cout` 1. With `x` all ones, `y` all ones and `cin` 1, the result is `sum` all ones and `cout` 1.
- R6: Widths that are not a power of two (N = 13) give results equal to `x + y + cin`, because unpaired groups move up a level unchanged.
- R7: Wide operands (N = 32) give results equal to `x + y + cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x    | input     | N     | First unsigned operand |
| y    | input     | N     | Second unsigned operand |
| cin  | input     | 1     | Carry into bit 0 |
| sum  | output    | N     | Low N bits of the total |
| cout | output    | 1     | Carry out of the top bit |

## Verification
Two things can happen in the same evaluation. The incoming carry is resolved in the lowest group, and that resolved carry then chooses the candidate of every upper group at every merge level. An all-ones operand with `cin` set provokes both at once. The carry must then pass through all the multiplexer levels and leave through `cout`, while every sum bit flips to zero. These cases, the exhaustive 8-bit sweep, and the random runs at 13 and 32 bits are all judged against a behavioural sum computed in the bench. The checker also confirms that the lowest group never holds two different candidates.

// File: rtl/condsum_pkg.sv
package condsum_pkg;

  // Number of merge levels needed to cover n bits.
  function automatic int csaLevels(input int n);
    return (n > 1) ? $clog2(n) : 0;
  endfunction

  // Number of groups of width gw needed to cover n bits.
  function automatic int csaGroups(input int n, input int gw);
    return (n + gw - 1) / gw;
  endfunction

endpackage

// File: rtl/csaBitCell.sv
module csaBitCell (
  input  logic xBit,
  input  logic yBit,
  output logic sumIfZero,
  output logic sumIfOne,
  output logic cyIfZero,
  output logic cyIfOne
);

  logic halfSum;

  assign halfSum   = xBit ^ yBit;
  assign sumIfZero = halfSum;
  assign sumIfOne  = ~halfSum;
  assign cyIfZero  = xBit & yBit;
  assign cyIfOne   = xBit | yBit;

endmodule

// File: rtl/csaMergeStage.sv
module csaMergeStage
  import condsum_pkg::*;
#(
  parameter int N  = 8,
  parameter int GW = 1
) (
  input  logic [N-1:0] sumIn0,
  input  logic [N-1:0] sumIn1,
  input  logic [N-1:0] cyIn0,
  input  logic [N-1:0] cyIn1,
  output logic [N-1:0] sumOut0,
  output logic [N-1:0] sumOut1,
  output logic [N-1:0] cyOut0,
  output logic [N-1:0] cyOut1
);

  localparam int OLD_GROUPS = csaGroups(N, GW);
  localparam int NEW_GROUPS = csaGroups(N, 2 * GW);

  // Sum bits: the upper half of a merged group is chosen by the lower half's carry.
  for (genvar b = 0; b < N; b++) begin : gBit
    localparam int OG = b / GW;
    if ((OG % 2) == 1) begin : gUpper
      assign sumOut0[b] = cyIn0[OG-1] ? sumIn1[b] : sumIn0[b];
      assign sumOut1[b] = cyIn1[OG-1] ? sumIn1[b] : sumIn0[b];
    end else begin : gLower
      assign sumOut0[b] = sumIn0[b];
      assign sumOut1[b] = sumIn1[b];
    end
  end

  // Group carries: merged, carried forward when unpaired, zero when unused.
  for (genvar g = 0; g < N; g++) begin : gGrp
    if (g < NEW_GROUPS) begin : gLive
      if ((2 * g + 1) < OLD_GROUPS) begin : gPair
        assign cyOut0[g] = cyIn0[2*g] ? cyIn1[2*g+1] : cyIn0[2*g+1];
        assign cyOut1[g] = cyIn1[2*g] ? cyIn1[2*g+1] : cyIn0[2*g+1];
      end else begin : gSolo
        assign cyOut0[g] = cyIn0[2*g];
        assign cyOut1[g] = cyIn1[2*g];
      end
    end else begin : gIdle
      assign cyOut0[g] = 1'b0;
      assign cyOut1[g] = 1'b0;
    end
  end

endmodule

// File: rtl/condSumAdder.sv
module condSumAdder
  import condsum_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);

  localparam int LEVELS = csaLevels(N);

  // Candidate state after each level; index 0 is the per-bit stage.
  logic [LEVELS:0][N-1:0] lvlSum0;
  logic [LEVELS:0][N-1:0] lvlSum1;
  logic [LEVELS:0][N-1:0] lvlCy0;
  logic [LEVELS:0][N-1:0] lvlCy1;

  logic [N-1:0] cellSum0, cellSum1, cellCy0, cellCy1;

  for (genvar b = 0; b < N; b++) begin : gCell
    csaBitCell uCell (
      .xBit      (x[b]),
      .yBit      (y[b]),
      .sumIfZero (cellSum0[b]),
      .sumIfOne  (cellSum1[b]),
      .cyIfZero  (cellCy0[b]),
      .cyIfOne   (cellCy1[b])
    );
  end

  // Bit 0 knows its carry already: keep only the candidate cin selects.
  logic lsbSum, lsbCy;
  assign lsbSum = cin ? cellSum1[0] : cellSum0[0];
  assign lsbCy  = cin ? cellCy1[0]  : cellCy0[0];

  for (genvar b = 0; b < N; b++) begin : gSeed
    if (b == 0) begin : gLsb
      assign lvlSum0[0][b] = lsbSum;
      assign lvlSum1[0][b] = lsbSum;
      assign lvlCy0[0][b]  = lsbCy;
      assign lvlCy1[0][b]  = lsbCy;
    end else begin : gRest
      assign lvlSum0[0][b] = cellSum0[b];
      assign lvlSum1[0][b] = cellSum1[b];
      assign lvlCy0[0][b]  = cellCy0[b];
      assign lvlCy1[0][b]  = cellCy1[b];
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : gLevel
    csaMergeStage #(.N(N), .GW(1 << l)) uMerge (
      .sumIn0  (lvlSum0[l]),
      .sumIn1  (lvlSum1[l]),
      .cyIn0   (lvlCy0[l]),
      .cyIn1   (lvlCy1[l]),
      .sumOut0 (lvlSum0[l+1]),
      .sumOut1 (lvlSum1[l+1]),
      .cyOut0  (lvlCy0[l+1]),
      .cyOut1  (lvlCy1[l+1])
    );
  end

  // One group remains; cin picks its set (both sets agree by construction of bit 0).
  assign sum  = cin ? lvlSum1[LEVELS] : lvlSum0[LEVELS];
  assign cout = cin ? lvlCy1[LEVELS][0] : lvlCy0[LEVELS][0];

endmodule

// File: rtl/condSumAdderChecker.sv
module condSumAdderChecker #(
  parameter int N      = 8,
  parameter int LEVELS = 3
) (
  input logic [N-1:0]          x,
  input logic [N-1:0]          y,
  input logic                  cin,
  input logic [N-1:0]          sum,
  input logic                  cout,
  input logic [LEVELS:0][N-1:0] lvlSum0,
  input logic [LEVELS:0][N-1:0] lvlSum1,
  input logic [LEVELS:0][N-1:0] lvlCy0,
  input logic [LEVELS:0][N-1:0] lvlCy1
);

  logic [N:0] refTotal;
  assign refTotal = {1'b0, x} + {1'b0, y} + {{N{1'b0}}, cin};

  always_comb begin
    assert_sum_R1: assert (sum == refTotal[N-1:0])
      else $error("sum mismatch");
    assert_carry_R2: assert (cout == refTotal[N])
      else $error("carry mismatch");
    for (int b = 1; b < N; b++) begin
      assert_cell_R3: assert (lvlSum0[0][b] == (x[b] ^ y[b]) &&
                              lvlSum1[0][b] == ~(x[b] ^ y[b]) &&
                              lvlCy0[0][b]  == (x[b] & y[b]) &&
                              lvlCy1[0][b]  == (x[b] | y[b]))
        else $error("bit candidates wrong");
    end
    for (int l = 0; l <= LEVELS; l++) begin
      assert_lsb_group_single_R4: assert (lvlCy0[l][0] == lvlCy1[l][0])
        else $error("lowest group carry split");
      for (int b = 0; b < N; b++) begin
        if (b < (1 << l)) begin
          assert_lsb_sum_single_R4: assert (lvlSum0[l][b] == lvlSum1[l][b])
            else $error("lowest group sum split");
        end
      end
    end
  end

endmodule

bind condSumAdder condSumAdderChecker #(.N(N), .LEVELS(LEVELS)) uChecker (
  .x       (x),
  .y       (y),
  .cin     (cin),
  .sum     (sum),
  .cout    (cout),
  .lvlSum0 (lvlSum0),
  .lvlSum1 (lvlSum1),
  .lvlCy0  (lvlCy0),
  .lvlCy1  (lvlCy1)
);

// File: tb/tb_condSumAdder.sv
module tb_condSumAdder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0]  x8,  y8;   logic c8;  logic [7:0]  s8;  logic co8;
  logic [12:0] x13, y13;  logic c13; logic [12:0] s13; logic co13;
  logic [31:0] x32, y32;  logic c32; logic [31:0] s32; logic co32;

  condSumAdder #(.N(8))  dut   (.x(x8),  .y(y8),  .cin(c8),  .sum(s8),  .cout(co8));
  condSumAdder #(.N(13)) dut13 (.x(x13), .y(y13), .cin(c13), .sum(s13), .cout(co13));
  condSumAdder #(.N(32)) dut32 (.x(x32), .y(y32), .cin(c32), .sum(s32), .cout(co32));

  // {x, y, cin, expected {cout,sum}}
  localparam logic [25:0] VEC [8] = '{
    {8'h00, 8'h00, 1'b0, 9'h000},
    {8'hFF, 8'h01, 1'b0, 9'h100},
    {8'hFF, 8'h00, 1'b1, 9'h100},
    {8'hFF, 8'hFF, 1'b1, 9'h1FF},
    {8'h55, 8'hAA, 1'b0, 9'h0FF},
    {8'h55, 8'hAA, 1'b1, 9'h100},
    {8'h80, 8'h80, 1'b0, 9'h100},
    {8'h0F, 8'h01, 1'b0, 9'h010}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0]  e8;
    logic [13:0] e13;
    logic [32:0] e32;
    x8 = '0; y8 = '0; c8 = 1'b0;
    x13 = '0; y13 = '0; c13 = 1'b0;
    x32 = '0; y32 = '0; c32 = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset-time zero sum", {55'd0, co8, s8}, 64'd0);
    rst = 1'b0;

    // Table of directed vectors (R1, R2, R5 corners)
    for (int i = 0; i < 8; i++) begin
      {x8, y8, c8} = VEC[i][25:9];
      #1;
      check("R1 table sum", {56'd0, s8}, {56'd0, VEC[i][7:0]});
      check("R2 table carry", {63'd0, co8}, {63'd0, VEC[i][8]});
    end

    // R5: carry entering at bit 0 crosses all levels, at 13 and 32 bits too
    x13 = '1; y13 = '0; c13 = 1'b1;
    x32 = '1; y32 = '0; c32 = 1'b1;
    #1;
    check("R5 13-bit full propagate", {50'd0, co13, s13}, {50'd0, 14'h2000});
    check("R5 32-bit full propagate", {31'd0, co32, s32}, {31'd0, 33'h1_0000_0000});
    y32 = '1;
    #1;
    check("R5 32-bit all ones plus cin", {31'd0, co32, s32}, {31'd0, 33'h1_FFFF_FFFF});

    // R3: alternate generate / kill / propagate pattern on every upper bit
    x8 = 8'b1101_1010; y8 = 8'b1011_0100; c8 = 1'b0;
    #1;
    e8 = {1'b0, x8} + {1'b0, y8};
    check("R3 mixed generate kill propagate", {55'd0, co8, s8}, {55'd0, e8});

    // R1/R2 exhaustive sweep at 8 bits
    begin
      int bad = 0;
      for (int i = 0; i < 131072; i++) begin
        {x8, y8, c8} = i[16:0];
        #1;
        e8 = {1'b0, x8} + {1'b0, y8} + {8'd0, c8};
        if ({co8, s8} !== e8) begin
          bad++;
          if (bad < 5)
            $display("FAIL R1/R2 sweep actual %0h expected %0h", {co8, s8}, e8);
        end
      end
      checks++;
      if (bad != 0) errors++;
    end

    // R6: non power-of-two width
    for (int i = 0; i < 300; i++) begin
      x13 = 13'($urandom); y13 = 13'($urandom); c13 = 1'($urandom);
      #1;
      e13 = {1'b0, x13} + {1'b0, y13} + {13'd0, c13};
      check("R6 13-bit random", {50'd0, co13, s13}, {50'd0, e13});
    end

    // R7: wide operands
    for (int i = 0; i < 300; i++) begin
      x32 = $urandom; y32 = $urandom; c32 = 1'($urandom);
      #1;
      e32 = {1'b0, x32} + {1'b0, y32} + {32'd0, c32};
      check("R7 32-bit random", {31'd0, co32, s32}, {31'd0, e32});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule